// File: doc/BRIEF.md
# Parallel Multi-Channel Accumulate Processor

This block applies one arithmetic operation to every channel word of a sample-memory row in a single command. A row holds one 24-bit signed word per ADC channel, with 36 channels by default. The command names two source rows (A and B), a destination row, an opcode, a shift amount and a signed coefficient.

The block reads row A, then row B. All channel lanes compute side by side, and the block writes the whole result row in one cycle. Frame differencing (correlated double sampling) and leaky running averages then cost one command per row, with no per-pixel processor loop.

An opcode can also turn raw conversions into stored 16-bit samples. A raw conversion is an upper 2-bit part and a lower 16-bit part. The block joins them into an 18-bit value and drops its two least significant bits.

The sample memory is external to the block. Its read port is synchronous: data appears the cycle after the read strobe. Every result is a 24-bit signed value. Where the requirements say so, the result saturates to the range -8388608..8388607.

Top module: `acc_array_proc`

## Requirements
- R1: One accepted command reads row `src_a`, then row `src_b`, and writes all NCH channel results to row `dst_row` in one write. Channel c occupies bits [c*24 +: 24] of a row.
- R2: Opcode 0 (add) gives A+B per channel, saturated to the signed 24-bit range.
- R3: Opcode 1 (subtract) gives A-B per channel, saturated to the signed 24-bit range.
- R4: Opcode 2 (shift) gives A shifted right arithmetically by `shift_amt`.
- R5: Opcode 3 (scale) gives product bits [39:16] of A times the signed 16-bit `coef`. This equals floor(A*coef/65536).
- R6: Opcode 4 (leaky) gives A - (A>>>k) + (B>>>k), saturated, where k is `shift_amt`. A is the accumulator and B is the new sample.
- R7: Opcode 5 (raw pack) takes bits [17:16] of A as the upper part and bits [15:0] of A as the lower part. It writes the joined 18-bit value shifted right by 2 and zero-extended, which is bits [17:2] of A.
- R8: Opcodes 6 and 7 write A unchanged.
- R9: Let the clock edge that samples `start` be edge 0. `mem_rd_en` is high with address `src_a` after edge 0, and with `src_b` after edge 1. `done` and `mem_wr_en` are high together for exactly one cycle after edge 3.
- R10: A `start` raised while `busy` is high is ignored. No extra write occurs, and the command in progress keeps its own fields.
- R11: During reset (synchronous, active-low) and after it, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are low until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| opcode | input | 3 | Operation select (see R2-R8) |
| src_a | input | AW | Row address of operand A |
| src_b | input | AW | Row address of operand B |
| dst_row | input | AW | Row address for the result |
| shift_amt | input | SHW | Shift amount for shift and leaky operations |
| coef | input | CW | Signed coefficient for scale |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Sample memory read strobe |
| mem_rd_addr | output | AW | Sample memory read row |
| mem_rd_data | input | NCH*W | Row data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Sample memory write strobe |
| mem_wr_addr | output | AW | Sample memory write row |
| mem_wr_data | output | NCH*W | Result row |

## Verification
Each result arrives a fixed four cycles after the edge that samples `start`. The two reads come after edges 0 and 1, the memory returns each row one cycle later, and the write and `done` come after edge 3. The bench drives and samples on falling edges. It checks the read strobe and address on the first two falling edges after `start`, and `done` on the fourth. It compares the destination row in its memory model only after the write edge.

For the ignored-start case, the bench counts writes and re-reads the row the second command aimed at, after the first command completes.

// File: rtl/ap_pkg.sv
// Package: shared opcode encoding for the parallel accumulate processor.
// Assumes: the 3-bit opcode field is decoded identically by every lane.
package ap_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_SHR   = 3'd2,
        OP_SCALE = 3'd3,
        OP_LEAK  = 3'd4,
        OP_RAW   = 3'd5,
        OP_CPY6  = 3'd6,
        OP_CPY7  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RDA  = 3'd1,
        ST_RDB  = 3'd2,
        ST_CAPB = 3'd3,
        ST_WB   = 3'd4
    } st_e;
endpackage

// File: rtl/ap_lane.sv
// Module: one channel lane. It combines word A and word B of a single
// channel according to the opcode and saturates where required.
// Assumes: W >= 18, so that the raw-pack field fits in the word; the
// operands are stable, registered values.
module ap_lane
    import ap_pkg::*;
#(
    parameter int W   = 24,
    parameter int SHW = 5,
    parameter int CW  = 16
) (
    input  op_e              op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SHW-1:0]   shamt,
    input  logic [CW-1:0]    coef,
    output logic [W-1:0]     res
);
    localparam int XW = W + 2;
    localparam int PW = W + CW;
    localparam logic signed [XW-1:0] MAXV = XW'(1 << (W - 1)) - XW'(1);
    localparam logic signed [XW-1:0] MINV = ~MAXV;

    logic signed [XW-1:0] ax, bx, a_sh, b_sh, wide;
    logic signed [W-1:0]  sa;
    logic signed [CW-1:0] sc;
    logic signed [PW-1:0] prod;

    // Sign-extend the operands and form the shifted and product terms.
    always_comb begin
        ax   = {{2{a[W-1]}}, a};
        bx   = {{2{b[W-1]}}, b};
        a_sh = ax >>> shamt;
        b_sh = bx >>> shamt;
        sa   = a;
        sc   = coef;
        prod = PW'(sa) * PW'(sc);
    end

    // Select the wide result for the opcode.
    always_comb begin
        case (op)
            OP_ADD:   wide = ax + bx;
            OP_SUB:   wide = ax - bx;
            OP_SHR:   wide = a_sh;
            OP_SCALE: wide = XW'($signed(prod[PW-1:CW]));
            OP_LEAK:  wide = ax - a_sh + b_sh;
            OP_RAW:   wide = XW'({2'b00, a[17:2]});
            default:  wide = ax;
        endcase
    end

    // Clamp to the signed W-bit range.
    always_comb begin
        if (wide > MAXV)      res = MAXV[W-1:0];
        else if (wide < MINV) res = MINV[W-1:0];
        else                  res = wide[W-1:0];
    end

    // R2
    always_comb begin
        if (op == OP_ADD && !a[W-1] && !b[W-1])
            add_no_wrap_chk: assert (!res[W-1]);
    end

    // R3
    always_comb begin
        if (op == OP_SUB && !a[W-1] && b[W-1])
            sub_no_wrap_chk: assert (!res[W-1]);
    end
endmodule

// File: rtl/ap_seq.sv
// Module: command sequencer. It issues the reads of rows A and B,
// captures the returned rows, then writes and pulses done.
// Assumes: the memory read port returns data one cycle after the strobe.
module ap_seq
    import ap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done,
    output logic rd_en,
    output logic rd_sel_b,
    output logic cap_a,
    output logic cap_b,
    output logic wr_en
);
    st_e st, st_nx;

    // Next-state logic: a fixed five-state walk per command.
    always_comb begin
        case (st)
            ST_IDLE: st_nx = start ? ST_RDA : ST_IDLE;
            ST_RDA:  st_nx = ST_RDB;
            ST_RDB:  st_nx = ST_CAPB;
            ST_CAPB: st_nx = ST_WB;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Decode the strobes from the state.
    always_comb begin
        accept   = (st == ST_IDLE) && start;
        busy     = (st != ST_IDLE);
        rd_en    = (st == ST_RDA) || (st == ST_RDB);
        rd_sel_b = (st == ST_RDB);
        cap_a    = (st == ST_RDB);
        cap_b    = (st == ST_CAPB);
        wr_en    = (st == ST_WB);
        done     = (st == ST_WB);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en, 3) && $past(rd_en, 2) && !$past(rd_en, 1)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done));
endmodule

// File: rtl/acc_array_proc.sv
// Module: top of the parallel accumulate processor. It latches a
// command, captures rows A and B from the sample memory, and runs NCH
// lanes in lock-step to produce one result row.
// Assumes: one row holds NCH words of W bits; the read latency is one cycle.
module acc_array_proc
    import ap_pkg::*;
#(
    parameter int NCH = 36,
    parameter int W   = 24,
    parameter int AW  = 8,
    parameter int SHW = 5,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [AW-1:0]     src_a,
    input  logic [AW-1:0]     src_b,
    input  logic [AW-1:0]     dst_row,
    input  logic [SHW-1:0]    shift_amt,
    input  logic [CW-1:0]     coef,
    output logic              busy,
    output logic              done,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [NCH*W-1:0]  mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [NCH*W-1:0]  mem_wr_data
);
    localparam int RW = NCH * W;

    logic          accept, cap_a, cap_b, sel_b;
    op_e           op_q;
    logic [AW-1:0] a_q, b_q, d_q;
    logic [SHW-1:0] sh_q;
    logic [CW-1:0] coef_q;
    logic [RW-1:0] row_a, row_b, row_res;

    ap_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .rd_en    (mem_rd_en),
        .rd_sel_b (sel_b),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .wr_en    (mem_wr_en)
    );

    // Latch the command fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_ADD;
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            sh_q   <= '0;
            coef_q <= '0;
        end else if (accept) begin
            op_q   <= op_e'(opcode);
            a_q    <= src_a;
            b_q    <= src_b;
            d_q    <= dst_row;
            sh_q   <= shift_amt;
            coef_q <= coef;
        end
    end

    // Capture the returned operand rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_a <= '0;
            row_b <= '0;
        end else begin
            if (cap_a) row_a <= mem_rd_data;
            if (cap_b) row_b <= mem_rd_data;
        end
    end

    // Route the addresses and the result row to the memory ports.
    always_comb begin
        mem_rd_addr = sel_b ? b_q : a_q;
        mem_wr_addr = d_q;
        mem_wr_data = row_res;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        ap_lane #(.W(W), .SHW(SHW), .CW(CW)) u_lane (
            .op    (op_q),
            .a     (row_a[c*W +: W]),
            .b     (row_b[c*W +: W]),
            .shamt (sh_q),
            .coef  (coef_q),
            .res   (row_res[c*W +: W])
        );
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(d_q) && $stable(a_q)));

    // R1
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> $stable(mem_wr_addr));
endmodule

// File: tb/sim_acc_array_proc.sv
`timescale 1ns/1ps
module sim_acc_array_proc;
    localparam int NCH = 36;
    localparam int W   = 24;
    localparam int AW  = 8;
    localparam int RW  = NCH * W;

    typedef struct packed {
        logic [2:0]  op;
        int          a0;
        int          b0;
        logic [4:0]  sh;
        logic [15:0] coef;
        int          exp0;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{3'd0, 1000, 234, 5'd0, 16'd0, 1234},                 // R2
        '{3'd1, 5000, 1200, 5'd0, 16'd0, 3800},                // R3
        '{3'd0, 8380000, 20000, 5'd0, 16'd0, 8388607},         // R2 saturate high
        '{3'd1, -8380000, 20000, 5'd0, 16'd0, -8388608},       // R3 saturate low
        '{3'd2, -1000, 0, 5'd3, 16'd0, -125},                  // R4
        '{3'd3, 1000, 0, 5'd0, 16'd16384, 250},                // R5
        '{3'd3, -1000, 0, 5'd0, 16'd16384, -250},              // R5 negative
        '{3'd4, 8000, 1600, 5'd3, 16'd0, 7200},                // R6
        '{3'd5, 32'h3FFFF, 0, 5'd0, 16'd0, 65535},             // R7
        '{3'd5, 32'h12345, 0, 5'd0, 16'd0, 18641},             // R7
        '{3'd1, 100, -200, 5'd0, 16'd0, 300},                  // R3 negative B
        '{3'd4, -8000, 0, 5'd2, 16'd0, -6000}                  // R6 negative
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] opcode = '0;
    logic [AW-1:0] src_a = '0, src_b = '0, dst_row = '0;
    logic [4:0] shift_amt = '0;
    logic [15:0] coef = '0;
    logic busy, done, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [RW-1:0] mem_rd_data, mem_wr_data;

    logic [RW-1:0] mem [16];
    int wr_cnt = 0;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    acc_array_proc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .dst_row(dst_row),
        .shift_amt(shift_amt), .coef(coef), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Sample memory model: synchronous read, one-cycle latency.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[3:0]];
        if (mem_wr_en) begin
            mem[mem_wr_addr[3:0]] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    initial begin
        #(8 * 200000);
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    function automatic longint sat24(longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    function automatic longint ref_op(int op, longint a, longint b, int sh, longint k);
        case (op)
            0: return sat24(a + b);
            1: return sat24(a - b);
            2: return a >>> sh;
            3: return (a * k) >>> 16;
            4: return sat24(a - (a >>> sh) + (b >>> sh));
            5: return (a & 64'h3FFFF) >> 2;
            default: return a;
        endcase
    endfunction

    function automatic longint word_at(logic [RW-1:0] row, int c);
        logic [W-1:0] w;
        w = row[c*W +: W];
        return longint'($signed(w));
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_row(int idx, int base, int step);
        for (int c = 0; c < NCH; c++) begin
            int v;
            v = base + step * c;
            mem[idx][c*W +: W] = v[W-1:0];
        end
    endtask

    // Issue one command at a falling edge; return the falling-edge count to done.
    task automatic run_cmd(int op, int a, int b, int d, int sh, int k, output int lat);
        opcode = op[2:0]; src_a = a[AW-1:0]; src_b = b[AW-1:0]; dst_row = d[AW-1:0];
        shift_amt = sh[4:0]; coef = k[15:0]; start = 1'b1;
        lat = 0;
        @(negedge clk); start = 1'b0; lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk); lat = lat + 1;
        end
        @(negedge clk);
    endtask

    // Compare every channel of a result row against the reference model.
    task automatic check_row(string req, int d, int op, int ra, int rb, int sh, int k);
        int bad;
        longint act, exp, bad_act, bad_exp;
        bad = 0; bad_act = 0; bad_exp = 0;
        for (int c = 0; c < NCH; c++) begin
            exp = ref_op(op, word_at(mem[ra], c), word_at(mem[rb], c), sh, longint'($signed(k[15:0])));
            act = word_at(mem[d], c);
            if (act != exp && bad == 0) begin
                bad = 1; bad_act = act; bad_exp = exp;
            end
        end
        check(req, bad_act, bad_exp);
    endtask

    initial begin
        int lat;
        int wc;
        longint saved;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet during reset
        check("R11 reset busy", busy, 0);
        check("R11 reset strobes", {mem_rd_en, mem_wr_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {busy, done, mem_rd_en, mem_wr_en}, 0);

        // Vector table walk: R1..R7
        for (int i = 0; i < NV; i++) begin
            fill_row(1, VT[i].a0, 37);
            fill_row(2, VT[i].b0, -11);
            run_cmd(VT[i].op, 1, 2, 4, VT[i].sh, VT[i].coef, lat);
            check($sformatf("R1 vec%0d op%0d ch0", i, VT[i].op), word_at(mem[4], 0), VT[i].exp0);
            check_row($sformatf("R1 vec%0d all channels", i), 4, VT[i].op, 1, 2, VT[i].sh, VT[i].coef);
        end

        // R8: reserved opcodes copy A
        fill_row(7, -4242, 101);
        fill_row(8, 999, 3);
        run_cmd(6, 7, 8, 9, 4, 77, lat);
        check_row("R8 op6 copy", 9, 6, 7, 8, 0, 0);
        run_cmd(7, 8, 7, 10, 4, 77, lat);
        check_row("R8 op7 copy", 10, 7, 8, 7, 0, 0);

        // R9: read sequence and done timing, sampled on falling edges
        opcode = 3'd0; src_a = 8'd1; src_b = 8'd2; dst_row = 8'd11; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R9 read A strobe", {mem_rd_en, mem_rd_addr}, {1'b1, 8'd1});
        @(negedge clk);
        check("R9 read B strobe", {mem_rd_en, mem_rd_addr}, {1'b1, 8'd2});
        @(negedge clk);
        check("R9 no done early", {done, mem_wr_en}, 0);
        @(negedge clk);
        check("R9 done and write", {done, mem_wr_en, mem_wr_addr}, {1'b1, 1'b1, 8'd11});
        @(negedge clk);
        check("R9 done one cycle", {done, busy}, 0);

        // R10: start during busy is ignored
        fill_row(5, 123456, 7);
        saved = word_at(mem[5], 3);
        wc = wr_cnt;
        opcode = 3'd0; src_a = 8'd1; src_b = 8'd2; dst_row = 8'd6; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        opcode = 3'd1; src_a = 8'd2; src_b = 8'd1; dst_row = 8'd5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        check("R10 single write", wr_cnt - wc, 1);
        check("R10 row untouched", word_at(mem[5], 3), saved);
        check_row("R10 first command intact", 6, 0, 1, 2, 0, 0);

        // R11: reset mid-command aborts and stays quiet
        opcode = 3'd0; src_a = 8'd1; src_b = 8'd2; dst_row = 8'd12; start = 1'b1;
        @(negedge clk); start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wc = wr_cnt;
        repeat (5) @(negedge clk);
        check("R11 reset aborts", {busy, done, wr_cnt - wc}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule